// File: doc/BRIEF.md
# Logarithmic-Step Wiper Register

This block keeps the position code of a 1024-position digital resistor. Besides a direct load, it offers two step commands that approximate a logarithmic adjustment. A step up doubles the code, which is about +6 dB, and a step down halves it, which is about -6 dB. Both are done by shifting the code by one bit.

The up step has two extra rules so that repeated use stays as close to a log curve as a binary code allows:

- A zero code has no bit to shift, so a step up from zero sets the code to one.
- A code whose top bit is already set cannot double, so a step up from there goes to full scale.

The down step is a plain logical shift toward zero. An odd code therefore loses its half-LSB without rounding.

A controller drives the block with single-cycle strobes. A load takes precedence over the step strobes in the same cycle. Conflicting step strobes leave the code where it is. Each accepted step is acknowledged by a one-cycle pulse.

Top module: `wiper_logstep`

## Requirements
- R1: While `rst` is high at a rising clock edge, `code` becomes 0 and `step_done` becomes 0 after that edge.
- R2: A step up (`step_up`=1, `step_dn`=0, `load_en`=0) on a code from 1 to 511 yields twice the code after the edge, with bit 0 cleared.
- R3: A step up on code 0 yields code 1.
- R4: A step up on any code of 512 or more (bit 9 set) yields 1023. Repeated steps up from 0 therefore give 1, 2, 4, ..., 512, 1023, 1023.
- R5: A step down (`step_dn`=1, `step_up`=0, `load_en`=0) yields the code shifted right by one bit, with bit 9 cleared and the old bit 0 discarded. Repeated steps down from 1023 therefore give 511, 255, ..., 3, 1, 0, 0.
- R6: When `load_en` is 1, `code` takes `load_code` after the edge, whatever the step strobes are, and `step_done` is 0 in the following cycle.
- R7: When `step_up` and `step_dn` are both 1 and `load_en` is 0, `code` is unchanged and `step_done` is 0 in the following cycle.
- R8: `step_done` is 1 for exactly the one cycle that follows each accepted single step. This includes steps that cannot move the code (up at 1023, down at 0). In every other case it is 0.
- R9: With no strobe and no load, `code` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Direct load strobe, highest priority |
| load_code | input | 10 | Code written on a load |
| step_up | input | 1 | Step-up (+6 dB) strobe |
| step_dn | input | 1 | Step-down (-6 dB) strobe |
| code | output | 10 | Current wiper code |
| step_done | output | 1 | One-cycle acknowledge of an accepted step |

## Verification
Every state of this block sits in the code register, so a wrong next-code value is visible on `code` in the first cycle after the faulty edge. A wrong saturation rule appears only at code 0 or at codes with the top bit set. For that reason, every one of the 1024 codes is stepped both ways and compared against a model. A wrong priority or a wrong acknowledge shows up one cycle after the conflicting strobes, either as a moved `code` or as a wrong `step_done`.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_UP   = 2'd2,
        OP_DN   = 2'd3
    } wiper_op_e;

    typedef struct packed {
        logic load;
        logic up;
        logic dn;
    } wiper_req_t;

    // Load wins; a lone step strobe is a step; anything else holds.
    function automatic wiper_op_e decode_req(input wiper_req_t r);
        wiper_op_e op;
        if (r.load)
            op = OP_LOAD;
        else if (r.up && !r.dn)
            op = OP_UP;
        else if (r.dn && !r.up)
            op = OP_DN;
        else
            op = OP_HOLD;
        return op;
    endfunction

    function automatic logic op_is_step(input wiper_op_e op);
        return (op == OP_UP) || (op == OP_DN);
    endfunction

endpackage

// File: rtl/wiper_op_arbiter.sv
module wiper_op_arbiter
    import wiper_pkg::*;
(
    input  logic      load_en,
    input  logic      step_up,
    input  logic      step_dn,
    output wiper_op_e op
);
    wiper_req_t req;

    always_comb begin
        req.load = load_en;
        req.up   = step_up;
        req.dn   = step_dn;
        op       = decode_req(req);
    end
endmodule

// File: rtl/wiper_step_calc.sv
module wiper_step_calc
    import wiper_pkg::*;
#(
    parameter int W = 10
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] load_val,
    input  wiper_op_e    op,
    output logic [W-1:0] nxt,
    output logic         is_step
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    logic [W-1:0] dbl;
    logic [W-1:0] half;
    logic [W-1:0] up_val;
    logic         at_zero;
    logic         top_set;

    // Bit wiring for the two shifts, zero filled at the vacated end.
    for (genvar i = 0; i < W; i++) begin : g_shift
        if (i == 0) begin : g_lo
            assign dbl[i] = 1'b0;
        end else begin : g_dbl
            assign dbl[i] = cur[i-1];
        end
        if (i == W-1) begin : g_hi
            assign half[i] = 1'b0;
        end else begin : g_half
            assign half[i] = cur[i+1];
        end
    end

    assign at_zero = (cur == '0);
    assign top_set = cur[W-1];

    always_comb begin
        if (at_zero)
            up_val = ONE;
        else if (top_set)
            up_val = FULL;
        else
            up_val = dbl;
    end

    always_comb begin
        unique case (op)
            OP_LOAD: nxt = load_val;
            OP_UP:   nxt = up_val;
            OP_DN:   nxt = half;
            default: nxt = cur;
        endcase
        is_step = op_is_step(op);
    end
endmodule

// File: rtl/wiper_code_reg.sv
module wiper_code_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] nxt,
    input  logic         is_step,
    output logic [W-1:0] code,
    output logic         done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
            done <= 1'b0;
        end else begin
            code <= nxt;
            done <= is_step;
        end
    end
endmodule

// File: rtl/wiper_logstep.sv
module wiper_logstep
    import wiper_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [W-1:0] load_code,
    input  logic         step_up,
    input  logic         step_dn,
    output logic [W-1:0] code,
    output logic         step_done
);
    localparam logic [W-1:0] MID  = W'(1) << (W-1);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    wiper_op_e    op;
    logic [W-1:0] nxt;
    logic         is_step;

    wiper_op_arbiter u_arb (
        .load_en (load_en),
        .step_up (step_up),
        .step_dn (step_dn),
        .op      (op)
    );

    wiper_step_calc #(.W(W)) u_calc (
        .cur      (code),
        .load_val (load_code),
        .op       (op),
        .nxt      (nxt),
        .is_step  (is_step)
    );

    wiper_code_reg #(.W(W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .nxt     (nxt),
        .is_step (is_step),
        .code    (code),
        .done    (step_done)
    );

    logic up_only;
    logic dn_only;
    assign up_only = step_up && !step_dn && !load_en;
    assign dn_only = step_dn && !step_up && !load_en;

    a_r2_double_mid: assert property (@(posedge clk) disable iff (rst)
        (up_only && code != '0 && code < MID) |=> (code == ($past(code) << 1)));
    a_r3_zero_to_one: assert property (@(posedge clk) disable iff (rst)
        (up_only && code == '0) |=> (code == W'(1)));
    a_r4_top_to_full: assert property (@(posedge clk) disable iff (rst)
        (up_only && code >= MID) |=> (code == FULL));
    a_r5_halve: assert property (@(posedge clk) disable iff (rst)
        dn_only |=> (code == ($past(code) >> 1)));
    a_r6_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (code == $past(load_code) && !step_done));
    a_r7_conflict_hold: assert property (@(posedge clk) disable iff (rst)
        (step_up && step_dn && !load_en) |=> ($stable(code) && !step_done));
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        (up_only || dn_only) |=> step_done);
    a_r8_done_only_after_step: assert property (@(posedge clk) disable iff (rst)
        !(up_only || dn_only) |=> !step_done);
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !step_up && !step_dn) |=> $stable(code));
endmodule

// File: tb/wiper_logstep_bench.sv
module wiper_logstep_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       load_en;
    logic [9:0] load_code;
    logic       step_up;
    logic       step_dn;
    logic [9:0] code;
    logic       step_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    wiper_logstep u_wiper_logstep (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_code (load_code),
        .step_up   (step_up),
        .step_dn   (step_dn),
        .code      (code),
        .step_done (step_done)
    );

    function automatic logic [9:0] model_up(input logic [9:0] c);
        if (c == 10'd0) return 10'd1;
        if (c >= 10'd512) return 10'd1023;
        return 10'(c * 2);
    endfunction

    function automatic logic [9:0] model_dn(input logic [9:0] c);
        return 10'(c / 2);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at the falling edge, clock once, sample 1 ns after the rising edge.
    task automatic cyc(input logic ld, input logic [9:0] val,
                       input logic up, input logic dn);
        @(negedge clk);
        load_en = ld; load_code = val; step_up = up; step_dn = dn;
        @(posedge clk);
        #1;
        load_en = 1'b0; step_up = 1'b0; step_dn = 1'b0;
    endtask

    task automatic t_reset;
        cyc(1'b1, 10'd700, 1'b0, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        check("R1 code", code, 0);
        check("R1 step_done", step_done, 0);
    endtask

    task automatic t_left_walk;
        logic [9:0] exp = 10'd0;
        cyc(1'b1, 10'd0, 1'b0, 1'b0);
        for (int i = 0; i < 13; i++) begin
            cyc(1'b0, 10'd0, 1'b1, 1'b0);
            exp = model_up(exp);
            check(i < 10 ? "R2/R3 up walk" : "R4 up walk", code, exp);
            check("R8 done after up", step_done, 1);
        end
        check("R4 walk end", code, 1023);
    endtask

    task automatic t_right_walk;
        logic [9:0] exp = 10'd1023;
        cyc(1'b1, 10'd1023, 1'b0, 1'b0);
        for (int i = 0; i < 13; i++) begin
            cyc(1'b0, 10'd0, 1'b0, 1'b1);
            exp = model_dn(exp);
            check("R5 down walk", code, exp);
            check("R8 done after down", step_done, 1);
        end
        check("R5 walk end", code, 0);
    endtask

    task automatic t_sweep;
        for (int c = 0; c < 1024; c++) begin
            cyc(1'b1, 10'(c), 1'b0, 1'b0);
            cyc(1'b0, 10'd0, 1'b1, 1'b0);
            check(c == 0 ? "R3 sweep" : (c >= 512 ? "R4 sweep" : "R2 sweep"),
                  code, model_up(10'(c)));
            cyc(1'b1, 10'(c), 1'b0, 1'b0);
            cyc(1'b0, 10'd0, 1'b0, 1'b1);
            check("R5 sweep", code, model_dn(10'(c)));
        end
    endtask

    task automatic t_odd_truncate;
        cyc(1'b1, 10'd3, 1'b0, 1'b0);
        cyc(1'b0, 10'd0, 1'b0, 1'b1);
        check("R5 odd 3", code, 1);
        cyc(1'b1, 10'd513, 1'b0, 1'b0);
        cyc(1'b0, 10'd0, 1'b0, 1'b1);
        check("R5 odd 513", code, 256);
    endtask

    task automatic t_load_priority;
        cyc(1'b1, 10'd100, 1'b0, 1'b0);
        cyc(1'b1, 10'd37, 1'b1, 1'b0);
        check("R6 load over up", code, 37);
        check("R6 no done", step_done, 0);
        cyc(1'b1, 10'd600, 1'b0, 1'b1);
        check("R6 load over dn", code, 600);
        cyc(1'b1, 10'd5, 1'b1, 1'b1);
        check("R6 load over both", code, 5);
        check("R6 no done both", step_done, 0);
    endtask

    task automatic t_conflict;
        cyc(1'b1, 10'd77, 1'b0, 1'b0);
        cyc(1'b0, 10'd0, 1'b1, 1'b1);
        check("R7 hold", code, 77);
        check("R7 no done", step_done, 0);
    endtask

    task automatic t_idle_and_pulse;
        cyc(1'b1, 10'd200, 1'b0, 1'b0);
        cyc(1'b0, 10'd0, 1'b0, 1'b1);
        check("R8 pulse", step_done, 1);
        cyc(1'b0, 10'd0, 1'b0, 1'b0);
        check("R8 pulse ends", step_done, 0);
        check("R9 idle hold", code, 100);
        cyc(1'b0, 10'd0, 1'b0, 1'b0);
        check("R9 idle hold 2", code, 100);
    endtask

    initial begin
        rst = 1'b1; load_en = 1'b0; load_code = '0; step_up = 1'b0; step_dn = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset code", code, 0);
        check("R1 reset done", step_done, 0);
        @(negedge clk); rst = 1'b0;
        t_left_walk();
        t_right_walk();
        t_odd_truncate();
        t_load_priority();
        t_conflict();
        t_idle_and_pulse();
        t_sweep();
        t_reset();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule